// File: doc/BRIEF.md
# Receive Character Queue with Level-Triggered Interrupt

This block buffers received characters between a serial receive shifter and a host. It holds up to sixteen bytes. The shifter offers each completed character on a valid/ready push port. The host takes characters out on a valid/ready pop port, where its ready strobe acts as the read. The block raises a receive-data interrupt once the number of stored characters reaches a threshold. A 2-bit select code chooses that threshold from a fixed table of four levels: 1, 4, 8 or 14.

The shifter cannot stall. For that reason `in_ready` is advisory only: it is low exactly when the queue is full. A character offered while the queue is full, with no read in the same cycle, is dropped and sets a sticky overrun flag. The pop side is a plain valid/ready stream. `out_valid` is high whenever the queue holds data, and a pop takes place on a cycle where `out_valid` and `out_ready` are both high. A separate flush input empties the queue in a single cycle.

Top module: `rxq_trigger_fifo`

## Requirements
- R1: After reset the queue is empty: `level`=0, `empty`=1, `full`=0, `overrun`=0, `rx_irq`=0, `in_ready`=1, `out_valid`=0. The select register holds code 00.
- R2: Characters leave through `out_data` in the order they were accepted. `out_data` shows the oldest stored character whenever `out_valid` is high.
- R3: `level` gives the number of stored characters (0 to 16). `empty` is high when `level` is 0, `full` is high when `level` is 16, and `in_ready` equals the inverse of `full`. A pop with no push lowers `level` by one.
- R4: A pop request while the queue is empty is ignored: `level` stays 0 and nothing is output.
- R5: A push on a full queue with no pop in the same cycle discards the character and leaves the stored contents and `level` unchanged. It also sets `overrun`, which stays set.
- R6: `ovr_clr` clears `overrun` on the next edge. If a new overrun occurs in the same cycle, `overrun` stays set.
- R7: A push and a pop in the same cycle on a full queue are both carried out. `full` stays high and `overrun` does not change.
- R8: Threshold codes on `trig_sel` map as follows: 00 to 1, 01 to 4, 10 to 8, 11 to 14. `rx_irq` is high exactly when `level` is greater than or equal to the threshold of the registered code.
- R9: `rx_irq` falls in the same cycle that a read brings `level` below the threshold, with no extra register delay.
- R10: A change on `trig_sel` is captured at the next clock edge. Until that edge, `rx_irq` keeps following the previous code.
- R11: `fifo_clr` empties the queue at the next edge and clears `overrun`. It takes priority over any push, pop or overrun in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| fifo_clr | input | 1 | Synchronous flush of the queue and overrun flag |
| ovr_clr | input | 1 | Clear of the sticky overrun flag |
| in_valid | input | 1 | Push request from the receive shifter |
| in_ready | output | 1 | High when a push will be stored (queue not full) |
| in_data | input | 8 | Character to push |
| out_valid | output | 1 | Queue holds at least one character |
| out_ready | input | 1 | Host read strobe; pops when out_valid is high |
| out_data | output | 8 | Oldest stored character |
| trig_sel | input | 2 | Interrupt threshold code |
| level | output | 5 | Stored character count |
| empty | output | 1 | Queue empty |
| full | output | 1 | Queue full |
| overrun | output | 1 | Sticky flag: a character was dropped |
| rx_irq | output | 1 | Receive-data interrupt |

## Verification
The bench writes to a full queue, then drains it. A design that let the dropped character overwrite a stored one would give a different byte order in the drain, and a design that forgot to set overrun would show the flag low. It also pushes and pops in the same cycle on a full queue, where a design that judged fullness before the pop would report a false overrun or lose a character. Each threshold code is tested one below its level and then at its level. One-off errors in the table or in the compare would show up there as an interrupt that is early or late. The bench also checks that a change of select code stays invisible until the next edge, and that a flush issued together with a push leaves the queue empty.

// File: rtl/rxq_pkg.sv
package rxq_pkg;
  // Fixed threshold table indexed by the 2-bit select code.
  function automatic int unsigned rxq_level(input logic [1:0] code);
    case (code)
      2'b00:   return 1;
      2'b01:   return 4;
      2'b10:   return 8;
      default: return 14;
    endcase
  endfunction
endpackage

// File: rtl/rxq_store.sv
module rxq_store #(
  parameter int W     = 8,
  parameter int DEPTH = 16,
  localparam int AW   = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [W-1:0]  wdata,
  input  logic [AW-1:0] raddr,
  output logic [W-1:0]  rdata
);
  logic [W-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
  end

  assign rdata = mem[raddr];
endmodule

// File: rtl/rxq_ctrl.sv
module rxq_ctrl #(
  parameter int DEPTH = 16,
  localparam int AW   = $clog2(DEPTH),
  localparam int CW   = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          clr,
  input  logic          push,
  input  logic          pop,
  input  logic          ovr_clr,
  output logic          wr_en,
  output logic [AW-1:0] wr_ptr,
  output logic [AW-1:0] rd_ptr,
  output logic [CW-1:0] count,
  output logic          ovr
);
  localparam logic [CW-1:0] FULLV = CW'(DEPTH);
  localparam logic [AW-1:0] LASTP = AW'(DEPTH - 1);

  logic do_pop, do_push, ovr_set, is_full;

  assign is_full = (count == FULLV);
  assign do_pop  = pop && (count != '0);
  assign do_push = push && (!is_full || do_pop);
  assign ovr_set = push && is_full && !do_pop;
  assign wr_en   = do_push && !clr;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      count  <= '0;
      ovr    <= 1'b0;
    end else if (clr) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      count  <= '0;
      ovr    <= 1'b0;
    end else begin
      if (do_push) wr_ptr <= (wr_ptr == LASTP) ? '0 : wr_ptr + 1'b1;
      if (do_pop)  rd_ptr <= (rd_ptr == LASTP) ? '0 : rd_ptr + 1'b1;
      case ({do_push, do_pop})
        2'b10:   count <= count + 1'b1;
        2'b01:   count <= count - 1'b1;
        default: count <= count;
      endcase
      if (ovr_set)      ovr <= 1'b1;
      else if (ovr_clr) ovr <= 1'b0;
    end
  end
endmodule

// File: rtl/rxq_trig.sv
module rxq_trig #(
  parameter int DEPTH = 16,
  localparam int CW   = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [1:0]    sel,
  input  logic [CW-1:0] count,
  output logic          irq
);
  import rxq_pkg::*;

  logic [1:0]    sel_q;
  logic [CW-1:0] thr;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sel_q <= 2'b00;
    else        sel_q <= sel;
  end

  assign thr = CW'(rxq_level(sel_q));
  assign irq = (count >= thr);
endmodule

// File: rtl/rxq_trigger_fifo.sv
module rxq_trigger_fifo #(
  parameter int W     = 8,
  parameter int DEPTH = 16,
  localparam int AW   = $clog2(DEPTH),
  localparam int CW   = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          fifo_clr,
  input  logic          ovr_clr,
  input  logic          in_valid,
  output logic          in_ready,
  input  logic [W-1:0]  in_data,
  output logic          out_valid,
  input  logic          out_ready,
  output logic [W-1:0]  out_data,
  input  logic [1:0]    trig_sel,
  output logic [CW-1:0] level,
  output logic          empty,
  output logic          full,
  output logic          overrun,
  output logic          rx_irq
);
  logic          wr_en;
  logic [AW-1:0] wr_ptr, rd_ptr;
  logic [CW-1:0] count;

  rxq_ctrl #(.DEPTH(DEPTH)) u_ctrl (
    .clk(clk), .rst_n(rst_n), .clr(fifo_clr), .push(in_valid), .pop(out_ready),
    .ovr_clr(ovr_clr), .wr_en(wr_en), .wr_ptr(wr_ptr), .rd_ptr(rd_ptr),
    .count(count), .ovr(overrun)
  );

  rxq_store #(.W(W), .DEPTH(DEPTH)) u_store (
    .clk(clk), .we(wr_en), .waddr(wr_ptr), .wdata(in_data),
    .raddr(rd_ptr), .rdata(out_data)
  );

  rxq_trig #(.DEPTH(DEPTH)) u_trig (
    .clk(clk), .rst_n(rst_n), .sel(trig_sel), .count(count), .irq(rx_irq)
  );

  assign level     = count;
  assign empty     = (count == '0);
  assign full      = (count == CW'(DEPTH));
  assign in_ready  = !full;
  assign out_valid = !empty;
endmodule

// File: rtl/rxq_checker.sv
module rxq_checker #(
  parameter int DEPTH = 16,
  localparam int CW   = $clog2(DEPTH + 1)
) (
  input logic          clk,
  input logic          rst_n,
  input logic          fifo_clr,
  input logic          ovr_clr,
  input logic          in_valid,
  input logic          out_ready,
  input logic [1:0]    trig_sel,
  input logic [CW-1:0] level,
  input logic          empty,
  input logic          full,
  input logic          overrun,
  input logic          rx_irq
);
  import rxq_pkg::*;

  assert_level_bound_R3: assert property (@(posedge clk) disable iff (!rst_n)
    level <= CW'(DEPTH));

  assert_pop_dec_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (!empty && out_ready && !in_valid && !fifo_clr) |=> (level == $past(level) - 1'b1));

  assert_pop_empty_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (empty && out_ready && !in_valid && !fifo_clr) |=> empty);

  assert_overrun_set_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (full && in_valid && !out_ready && !fifo_clr) |=> (overrun && full));

  assert_ovr_clear_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (ovr_clr && !fifo_clr && !(full && in_valid && !out_ready)) |=> !overrun);

  assert_full_swap_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (full && in_valid && out_ready && !fifo_clr && !ovr_clr) |=> (full && overrun == $past(overrun)));

  assert_irq_level_R8: assert property (@(posedge clk) disable iff (!rst_n)
    $past(rst_n) |-> (rx_irq == (level >= CW'(rxq_level($past(trig_sel))))));

  assert_flush_R11: assert property (@(posedge clk) disable iff (!rst_n)
    fifo_clr |=> (empty && !overrun));
endmodule

bind rxq_trigger_fifo rxq_checker #(.DEPTH(DEPTH)) u_chk (
  .clk(clk), .rst_n(rst_n), .fifo_clr(fifo_clr), .ovr_clr(ovr_clr),
  .in_valid(in_valid), .out_ready(out_ready), .trig_sel(trig_sel),
  .level(level), .empty(empty), .full(full), .overrun(overrun), .rx_irq(rx_irq)
);

// File: tb/sim_rxq_trigger_fifo.sv
`timescale 1ns/1ps
module sim_rxq_trigger_fifo;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic fifo_clr = 1'b0, ovr_clr = 1'b0, in_valid = 1'b0, out_ready = 1'b0;
  logic [7:0] in_data = 8'h00;
  logic [1:0] trig_sel = 2'b00;
  logic in_ready, out_valid, empty, full, overrun, rx_irq;
  logic [7:0] out_data;
  logic [4:0] level;

  int total = 0, bad = 0;
  logic [7:0] q[$];
  int thr_tab[4] = '{1, 4, 8, 14};

  always #2 clk = ~clk;

  rxq_trigger_fifo u0 (
    .clk(clk), .rst_n(rst_n), .fifo_clr(fifo_clr), .ovr_clr(ovr_clr),
    .in_valid(in_valid), .in_ready(in_ready), .in_data(in_data),
    .out_valid(out_valid), .out_ready(out_ready), .out_data(out_data),
    .trig_sel(trig_sel), .level(level), .empty(empty), .full(full),
    .overrun(overrun), .rx_irq(rx_irq)
  );

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  // Driver: applies one cycle of stimulus and records accepted pushes.
  task automatic cyc(input logic p, input logic [7:0] d, input logic r,
                     input logic c, input logic oc);
    @(negedge clk);
    in_valid = p; in_data = d; out_ready = r; fifo_clr = c; ovr_clr = oc;
    if (c) q.delete();
    else if (p && (q.size() < 16 || (r && q.size() > 0))) q.push_back(d);
    @(posedge clk);
    #1;
    in_valid = 1'b0; out_ready = 1'b0; fifo_clr = 1'b0; ovr_clr = 1'b0;
  endtask

  // Monitor: compares each popped character against the scoreboard (R2).
  initial begin
    forever begin
      @(negedge clk);
      #1;
      if (rst_n && out_valid && out_ready && !fifo_clr) begin
        if (q.size() == 0) chk(1'b0, "R2 pop with empty scoreboard", out_data, -1);
        else begin
          logic [7:0] e;
          e = q.pop_front();
          chk(out_data == e, "R2 output order", out_data, e);
        end
      end
    end
  end

  initial begin
    #(4 * 200000);
    bad++;
    $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    #1;
    chk(level == 0 && empty && !full, "R1 reset level", level, 0);
    chk(!overrun && !rx_irq, "R1 reset flags", {overrun, rx_irq}, 0);
    chk(in_ready && !out_valid, "R1 reset handshake", {in_ready, out_valid}, 2);
    @(negedge clk);
    rst_n = 1'b1;

    // R4: pop on empty
    cyc(0, 8'h00, 1, 0, 0);
    chk(level == 0 && empty, "R4 pop on empty", level, 0);

    // R8 code 00: one char raises irq
    cyc(1, 8'hA1, 0, 0, 0);
    chk(rx_irq, "R8 code00 at 1", rx_irq, 1);
    chk(level == 1 && !empty, "R3 level after push", level, 1);
    cyc(0, 8'h00, 1, 0, 0);
    chk(!rx_irq && empty, "R9 irq drops on read", rx_irq, 0);

    // R3/R5: fill, then overflow
    for (int i = 0; i < 16; i++) cyc(1, 8'h40 + 8'(i), 0, 0, 0);
    chk(full && level == 16, "R3 full at 16", level, 16);
    chk(!in_ready, "R3 in_ready low when full", in_ready, 0);
    cyc(1, 8'hEE, 0, 0, 0);
    chk(overrun, "R5 overrun set", overrun, 1);
    chk(level == 16, "R5 level unchanged", level, 16);
    cyc(0, 8'h00, 0, 0, 0);
    chk(overrun, "R5 overrun sticky", overrun, 1);

    // R6: clear, then clear with simultaneous overrun
    cyc(0, 8'h00, 0, 0, 1);
    chk(!overrun, "R6 ovr_clr clears", overrun, 0);
    cyc(1, 8'hEF, 0, 0, 1);
    chk(overrun, "R6 new overrun wins", overrun, 1);
    cyc(0, 8'h00, 0, 0, 1);

    // R7: push+pop on full
    cyc(1, 8'h77, 1, 0, 0);
    chk(full && level == 16, "R7 full kept", level, 16);
    chk(!overrun, "R7 no overrun", overrun, 0);

    // R2/R5: drain and compare (discarded chars never appear)
    for (int i = 0; i < 16; i++) cyc(0, 8'h00, 1, 0, 0);
    chk(empty && level == 0, "R3 drained", level, 0);

    // R8: each code, one below and at its threshold
    for (int s = 0; s < 4; s++) begin
      trig_sel = 2'(s);
      cyc(0, 8'h00, 0, 1, 0);
      for (int i = 0; i < thr_tab[s] - 1; i++) cyc(1, 8'(s * 16 + i), 0, 0, 0);
      chk(!rx_irq, "R8 below threshold", level, thr_tab[s] - 1);
      cyc(1, 8'hC0 + 8'(s), 0, 0, 0);
      chk(rx_irq, "R8 at threshold", level, thr_tab[s]);
    end

    // R9: code 10 at level 8, read one
    trig_sel = 2'b10;
    cyc(0, 8'h00, 0, 1, 0);
    for (int i = 0; i < 8; i++) cyc(1, 8'h90 + 8'(i), 0, 0, 0);
    chk(rx_irq, "R9 irq at 8", rx_irq, 1);
    cyc(0, 8'h00, 1, 0, 0);
    chk(!rx_irq && level == 7, "R9 irq drops at 7", level, 7);

    // R10: select change delayed one edge (level 7)
    trig_sel = 2'b00;
    cyc(0, 8'h00, 0, 0, 0);
    chk(rx_irq, "R10 code00 active", rx_irq, 1);
    @(negedge clk);
    trig_sel = 2'b11;
    #1;
    chk(rx_irq, "R10 old code holds before edge", rx_irq, 1);
    @(posedge clk);
    #1;
    chk(!rx_irq, "R10 new code after edge", rx_irq, 0);

    // R11: flush with push and overrun
    for (int i = 0; i < 9; i++) cyc(1, 8'hB0 + 8'(i), 0, 0, 0);
    cyc(1, 8'hBF, 0, 0, 0);
    chk(overrun, "R11 setup overrun", overrun, 1);
    cyc(1, 8'hDD, 0, 1, 0);
    chk(empty && level == 0, "R11 flush empties", level, 0);
    chk(!overrun && !rx_irq, "R11 flush clears overrun", overrun, 0);
    cyc(1, 8'h5A, 0, 0, 0);
    cyc(0, 8'h00, 1, 0, 0);
    chk(q.size() == 0 && empty, "R11 fresh order after flush", q.size(), 0);

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule